// File: doc/BRIEF.md
# External Memory Cycle Sequencer

This block is a host-side bus master for an 8-bit processor memory bus. It runs timed read and write cycles while the host already owns the bus. Bus arbitration happens elsewhere, and this block assumes the right to drive the bus has been granted. A cycle starts on a one-clock start pulse. The pulse latches a 19-bit address, a write byte, a 32-bit byte count and an operation mode. The block then drives the active-low memory-request, read and write strobes, the address lanes and a tri-state data bus. The data bus is brought out as separate output, output-enable and input pins.

There are four modes:
- **Single read** captures one byte into `rdata_o`.
- **Single write** stores one byte.
- **Fill** stores the same byte at a run of consecutive addresses.
- **Copy** stores bytes taken from a ready/valid input stream at consecutive addresses.

In the two burst modes the memory request stays asserted for the whole run. Each byte gets its own write pulse, and the address steps by one between bytes. Strobe and data-phase widths are fixed numbers of host clocks, set by parameters. A one-clock `done_o` pulse marks the end of every operation.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset and whenever `busy_o` is low, `mreq_n_o`, `rd_n_o` and `wr_n_o` are 1, `bus_oe_o` is 0, and `done_o` and `src_ready_o` are 0.
- R2: The address is presented as `adr_lo_o` (bits 7:0), `adr_hi_o` (bits 15:8) and `adr_ext_o` (bits 18:16). It does not change while a read or write strobe is low.
- R3: A write byte is performed in this order:
  - after `mreq_n_o` falls, `bus_oe_o` is 1 with `wr_n_o` high for exactly 2 clocks;
  - `wr_n_o` is then low for exactly 2 clocks while the data stays driven;
  - `wr_n_o` rises while `mreq_n_o` is still low and the data is still driven.
- R4: A read cycle keeps `bus_oe_o` at 0 and holds `rd_n_o` low for exactly 3 clocks. `rdata_o` then holds the value present on `bus_din_i` in the last low clock.
- R5: Fill writes the `wdata_i` byte to `len_i` consecutive addresses starting at `addr_i`. The address carries across the 8-bit and 16-bit lane boundaries.
- R6: Copy writes `len_i` bytes taken in order from the stream at consecutive addresses. A byte is taken on a clock where `src_valid_i` and `src_ready_o` are both 1. While no byte is offered, the sequence waits with `mreq_n_o` held low.
- R7: In a burst with `len_i` > 0, `mreq_n_o` falls exactly once and stays low until the last byte completes. There is exactly one write pulse per byte.
- R8: A fill or copy with `len_i` = 0 produces no strobe and no fall of `mreq_n_o`. It signals `done_o` on the clock after the start.
- R9: `done_o` is a single-clock pulse, given once per operation, in the first clock after the final rise of `mreq_n_o` (with `mreq_n_o` high).
- R10: `start_i` is ignored while `busy_o` is 1.
- R11: Single read and single write perform exactly one byte whatever the value of `len_i`.
- R12: The `mode_i` encoding is 0 for single read, 1 for single write, 2 for fill and 3 for copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-clock request to begin an operation |
| mode_i | input | 2 | Operation mode (0 read, 1 write, 2 fill, 3 copy) |
| addr_i | input | 19 | Start address |
| wdata_i | input | 8 | Byte for single write and fill |
| len_i | input | 32 | Byte count for the burst modes |
| src_valid_i | input | 1 | Stream byte offered (copy mode) |
| src_data_i | input | 8 | Stream byte |
| src_ready_o | output | 1 | Sequencer accepts a stream byte |
| rdata_o | output | 8 | Byte captured by the last read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one clock) |
| adr_lo_o | output | 8 | Address bits 7:0 |
| adr_hi_o | output | 8 | Address bits 15:8 |
| adr_ext_o | output | 3 | Address bits 18:16 |
| mreq_n_o | output | 1 | Memory request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| bus_dout_o | output | 8 | Data driven onto the bus |
| bus_oe_o | output | 1 | Data bus drive enable |
| bus_din_i | input | 8 | Data read from the bus |

## Verification
The hardest situation to reach is a copy burst that stalls between bytes for lack of a source byte. That stall must happen while the memory request is already low and the address is stepping across a 16-bit lane boundary. The stimulus reaches it by starting a copy just below the boundary, at 0x3FFFD. During that copy the source is offered only on one clock in four, so several between-byte waits fall inside one request.

A second hard case is a new start arriving in the middle of a fill. The bench raises a read start a few clocks into the burst and then shows that no read strobe and no second request appear.

// File: rtl/mcs_pkg.sv
// Shared types for the memory cycle sequencer.
package mcs_pkg;

    // Operation mode as seen on the mode input (R12)
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_FILL  = 2'd2,
        MODE_COPY  = 2'd3
    } mode_e;

    // Sequencer phases, one host clock or more each
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FINISH
    } state_e;

    function automatic logic is_burst(input mode_e m);
        return (m == MODE_FILL) || (m == MODE_COPY);
    endfunction

    function automatic logic is_write(input mode_e m);
        return m != MODE_READ;
    endfunction

endpackage

// File: rtl/mcs_addr_gen.sv
// Address register and incrementer.
// Loads the start address, steps it by one between burst bytes and splits
// it into two byte lanes plus an extension lane.
// Assumes ADDR_W is larger than two lanes.
module mcs_addr_gen #(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [ADDR_W-1:0]            base_i,
    input  logic                         step_i,
    output logic [LANE_W-1:0]            lo_o,
    output logic [LANE_W-1:0]            hi_o,
    output logic [ADDR_W-2*LANE_W-1:0]   ext_o
);
    localparam int EXT_W = ADDR_W - 2*LANE_W;

    logic [ADDR_W-1:0] addr_q;

    // Hold the current bus address; load on start, +1 per burst byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Lane split of the address register
    always_comb begin
        lo_o  = addr_q[LANE_W-1:0];
        hi_o  = addr_q[2*LANE_W-1:LANE_W];
        ext_o = addr_q[ADDR_W-1:ADDR_W-EXT_W];
    end

endmodule

// File: rtl/mcs_len_cnt.sv
// Remaining-byte counter.
// Loaded with the burst length, or with one for single cycles.
// Decremented after each byte that is not the last one.
module mcs_len_cnt #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             single_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic             last_o,
    output logic             len_zero_o
);
    logic [LEN_W-1:0] rem_q;

    // Track bytes still to be performed in the current operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= single_i ? LEN_W'(1) : len_i;
        end else if (dec_i) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    // Flags for the controller
    always_comb begin
        last_o     = (rem_q == LEN_W'(1));
        len_zero_o = (len_i == '0);
    end

    // R7
    rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (rem_q > LEN_W'(1)));

endmodule

// File: rtl/mcs_data_path.sv
// Write-byte register and read-capture register.
// The write byte comes either from the constant input or from the stream.
// The read byte is captured from the bus on the controller's command.
module mcs_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_const_i,
    input  logic [DATA_W-1:0] const_i,
    input  logic              take_src_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] wbyte_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] wbyte_q;
    logic [DATA_W-1:0] rdata_q;

    // Byte to drive on the bus during write phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
        end else if (take_src_i) begin
            wbyte_q <= src_i;
        end else if (load_const_i) begin
            wbyte_q <= const_i;
        end
    end

    // Byte sampled from the bus at the end of the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_i) begin
            rdata_q <= bus_i;
        end
    end

    assign wbyte_o = wbyte_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/mcs_ctrl.sv
// Phase controller for the memory cycle sequencer.
// Walks address, fetch, data setup, strobe and hold phases for each byte.
// In burst modes it keeps the memory request low between bytes.
// Assumes the bus drive right is already granted.
module mcs_ctrl
    import mcs_pkg::*;
#(
    parameter int WR_DATA_CLKS   = 2,
    parameter int WR_STROBE_CLKS = 2,
    parameter int RD_STROBE_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       len_zero_i,
    input  logic       last_i,
    input  logic       src_valid_i,
    output logic       load_o,
    output logic       step_o,
    output logic       take_o,
    output logic       cap_o,
    output logic       single_o,
    output logic       src_ready_o,
    output logic       mreq_n_o,
    output logic       rd_n_o,
    output logic       wr_n_o,
    output logic       oe_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int MAX_A    = (WR_DATA_CLKS > WR_STROBE_CLKS) ? WR_DATA_CLKS : WR_STROBE_CLKS;
    localparam int MAX_CLKS = (MAX_A > RD_STROBE_CLKS) ? MAX_A : RD_STROBE_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] WD_LAST = CNT_W'(WR_DATA_CLKS - 1);
    localparam logic [CNT_W-1:0] WS_LAST = CNT_W'(WR_STROBE_CLKS - 1);
    localparam logic [CNT_W-1:0] RS_LAST = CNT_W'(RD_STROBE_CLKS - 1);

    state_e           state_q, state_d;
    mode_e            mode_q, mode_d, mode_in;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             inburst_q, inburst_d;
    logic [CNT_W-1:0] setup_last, strobe_last;
    logic             wr_mode;
    logic             in_byte;

    assign mode_in     = mode_e'(mode_i);
    assign wr_mode     = is_write(mode_q);
    assign setup_last  = wr_mode ? WD_LAST : '0;
    assign strobe_last = wr_mode ? WS_LAST : RS_LAST;
    assign single_o    = !is_burst(mode_in);

    // Next-phase decision and per-phase datapath commands
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        cnt_d     = cnt_q;
        inburst_d = inburst_q;
        load_o    = 1'b0;
        step_o    = 1'b0;
        take_o    = 1'b0;
        cap_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o    = 1'b1;
                    mode_d    = mode_in;
                    inburst_d = 1'b0;
                    cnt_d     = '0;
                    state_d   = (is_burst(mode_in) && len_zero_i) ? ST_FINISH : ST_ADDR;
                end
            end
            ST_ADDR: begin
                cnt_d   = '0;
                state_d = (mode_q == MODE_COPY) ? ST_FETCH : ST_SETUP;
            end
            ST_FETCH: begin
                if (src_valid_i) begin
                    take_o  = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cnt_q == setup_last) begin
                    cnt_d   = '0;
                    state_d = ST_STROBE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_q == strobe_last) begin
                    cap_o   = !wr_mode;
                    cnt_d   = '0;
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (last_i) begin
                    state_d = ST_FINISH;
                end else begin
                    step_o    = 1'b1;
                    inburst_d = 1'b1;
                    state_d   = (mode_q == MODE_COPY) ? ST_FETCH : ST_SETUP;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase, mode, width-counter and burst-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_READ;
            cnt_q     <= '0;
            inburst_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            mode_q    <= mode_d;
            cnt_q     <= cnt_d;
            inburst_q <= inburst_d;
        end
    end

    // Bus strobes and status decoded from the current phase
    always_comb begin
        in_byte     = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        mreq_n_o    = !(in_byte || ((state_q == ST_FETCH) && inburst_q));
        oe_o        = in_byte && wr_mode;
        wr_n_o      = !((state_q == ST_STROBE) && wr_mode);
        rd_n_o      = !((state_q == ST_STROBE) && !wr_mode);
        src_ready_o = (state_q == ST_FETCH);
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FINISH);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mreq_n_o && rd_n_o && wr_n_o && !oe_o && !done_o && !src_ready_o));
    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !oe_o);
    // R3
    wr_in_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (!mreq_n_o && oe_o));
    // R3
    wr_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> (!mreq_n_o && oe_o));
    // R9
    done_mreq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> mreq_n_o);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    stall_holds_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready_o && !src_valid_i && !mreq_n_o) |=> !mreq_n_o);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

endmodule

// File: rtl/mem_cycle_seq.sv
// External memory cycle sequencer (top).
// Runs single read, single write, fill and copy operations on an 8-bit
// memory bus with fixed strobe widths. The data bus is split into drive,
// enable and sense pins. Bus ownership is assumed granted.
module mem_cycle_seq
    import mcs_pkg::*;
#(
    parameter int ADDR_W         = 19,
    parameter int LANE_W         = 8,
    parameter int DATA_W         = 8,
    parameter int LEN_W          = 32,
    parameter int WR_DATA_CLKS   = 2,
    parameter int WR_STROBE_CLKS = 2,
    parameter int RD_STROBE_CLKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [1:0]                  mode_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic                        src_valid_i,
    input  logic [DATA_W-1:0]           src_data_i,
    output logic                        src_ready_o,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [LANE_W-1:0]           adr_lo_o,
    output logic [LANE_W-1:0]           adr_hi_o,
    output logic [ADDR_W-2*LANE_W-1:0]  adr_ext_o,
    output logic                        mreq_n_o,
    output logic                        rd_n_o,
    output logic                        wr_n_o,
    output logic [DATA_W-1:0]           bus_dout_o,
    output logic                        bus_oe_o,
    input  logic [DATA_W-1:0]           bus_din_i
);
    logic load, step, take, cap, single, last, len_zero;

    mcs_ctrl #(
        .WR_DATA_CLKS  (WR_DATA_CLKS),
        .WR_STROBE_CLKS(WR_STROBE_CLKS),
        .RD_STROBE_CLKS(RD_STROBE_CLKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .len_zero_i (len_zero),
        .last_i     (last),
        .src_valid_i(src_valid_i),
        .load_o     (load),
        .step_o     (step),
        .take_o     (take),
        .cap_o      (cap),
        .single_o   (single),
        .src_ready_o(src_ready_o),
        .mreq_n_o   (mreq_n_o),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .oe_o       (bus_oe_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    mcs_addr_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .base_i(addr_i),
        .step_i(step),
        .lo_o  (adr_lo_o),
        .hi_o  (adr_hi_o),
        .ext_o (adr_ext_o)
    );

    mcs_len_cnt #(.LEN_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .single_i  (single),
        .len_i     (len_i),
        .dec_i     (step),
        .last_o    (last),
        .len_zero_o(len_zero)
    );

    mcs_data_path #(.DATA_W(DATA_W)) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_const_i(load),
        .const_i     (wdata_i),
        .take_src_i  (take),
        .src_i       (src_data_i),
        .cap_i       (cap),
        .bus_i       (bus_din_i),
        .wbyte_o     (bus_dout_o),
        .rdata_o     (rdata_o)
    );

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o || !rd_n_o) |-> $stable({adr_ext_o, adr_hi_o, adr_lo_o}));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/test_mem_cycle_seq.sv
module test_mem_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] len = '0;
    logic        src_valid;
    logic [7:0]  src_data;
    logic        src_ready;
    logic [7:0]  rdata;
    logic        busy, done;
    logic [7:0]  alo, ahi;
    logic [2:0]  aext;
    logic        mreq_n, rd_n, wr_n;
    logic [7:0]  dout, din;
    logic        oe;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    mem_cycle_seq i_mem_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .addr_i(addr), .wdata_i(wdata), .len_i(len),
        .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
        .rdata_o(rdata), .busy_o(busy), .done_o(done),
        .adr_lo_o(alo), .adr_hi_o(ahi), .adr_ext_o(aext),
        .mreq_n_o(mreq_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
        .bus_dout_o(dout), .bus_oe_o(oe), .bus_din_i(din)
    );

    // Memory model: read data is a function of the address
    function automatic logic [7:0] rd_pat(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hC3;
    endfunction
    assign din = !rd_n ? rd_pat({aext, ahi, alo}) : 8'hEE;

    // Stream source: byte k is 0x30+k, optionally offered one clock in four
    int   src_idx = 0;
    logic gap_en = 1'b0;
    logic [1:0] cyc = '0;
    assign src_valid = gap_en ? (cyc == 2'd0) : 1'b1;
    assign src_data  = 8'h30 + 8'(src_idx);
    initial begin
        forever begin
            @(posedge clk);
            cyc <= cyc + 2'd1;
            if (src_valid && src_ready) src_idx <= src_idx + 1;
        end
    end

    // Bus monitor
    logic [7:0] mem [int];
    int n_wr, n_rd, n_mfall, n_done, wr_w, rd_w, pre_cnt;
    int e_wwidth, e_rwidth, e_setup, e_hold, e_cont, e_done;
    logic p_mreq_n = 1'b1, p_wr_n = 1'b1, p_rd_n = 1'b1;

    task automatic clear_stats();
        n_wr = 0; n_rd = 0; n_mfall = 0; n_done = 0; wr_w = 0; rd_w = 0; pre_cnt = 0;
        e_wwidth = 0; e_rwidth = 0; e_setup = 0; e_hold = 0; e_cont = 0; e_done = 0;
        mem.delete();
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_mreq_n && !mreq_n) n_mfall++;
            if (!wr_n) wr_w++;
            if (p_wr_n && !wr_n && pre_cnt != 2) e_setup++;
            if (!p_wr_n && wr_n) begin
                n_wr++;
                if (wr_w != 2) e_wwidth++;
                if (mreq_n || !oe) e_hold++;
                mem[int'({aext, ahi, alo})] = dout;
                wr_w = 0;
                pre_cnt = 0;
            end else if (wr_n && oe && !mreq_n) begin
                pre_cnt++;
            end
            if (!rd_n) begin
                rd_w++;
                if (oe) e_cont++;
            end
            if (!p_rd_n && rd_n) begin
                n_rd++;
                if (rd_w != 3) e_rwidth++;
                rd_w = 0;
            end
            if (done) begin
                n_done++;
                if (!mreq_n) e_done++;
            end
        end
        p_mreq_n = mreq_n;
        p_wr_n   = wr_n;
        p_rd_n   = rd_n;
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(mreq_n && rd_n && wr_n && !oe && !busy && !done && !src_ready, tag,
              {mreq_n, rd_n, wr_n, oe, busy, done, src_ready}, 7'b1110000);
    endtask

    // Stimulus and expected-result table (mode: 0 read, 1 write, 2 fill, 3 copy)
    localparam int NV = 10;
    localparam logic [1:0]  V_MODE [NV] = '{2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd3, 2'd3, 2'd2, 2'd3};
    localparam logic [18:0] V_ADDR [NV] = '{19'h00012, 19'h7FFFF, 19'h12345, 19'h40000, 19'h0FFFE,
                                            19'h00100, 19'h20000, 19'h3FFFD, 19'h00200, 19'h00300};
    localparam logic [7:0]  V_DATA [NV] = '{8'hA5, 8'h3C, 8'h00, 8'h00, 8'h77, 8'h11, 8'h00, 8'h00, 8'h99, 8'h00};
    localparam int          V_LEN  [NV] = '{0, 9, 7, 0, 4, 1, 5, 6, 0, 0};
    localparam logic        V_GAP  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam int          V_NWR  [NV] = '{1, 1, 0, 0, 4, 1, 5, 6, 0, 0};
    localparam int          V_NRD  [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0};

    task automatic run_op(input logic [1:0] m, input logic [18:0] a, input logic [7:0] d,
                          input int n, input logic gap, input int exp_wr, input int exp_rd,
                          input logic poke);
        string tag;
        int t;
        logic [18:0] ea;
        logic [7:0]  eb;
        case (m)
            2'd0: tag = "R4 read";
            2'd1: tag = "R3/R11 write";
            2'd2: tag = (n == 0) ? "R8 fill-zero" : "R5 fill";
            default: tag = (n == 0) ? "R8 copy-zero" : "R6 copy";
        endcase
        clear_stats();
        src_idx = 0;
        gap_en = gap;
        @(negedge clk);
        start = 1'b1; mode = m; addr = a; wdata = d; len = 32'(n);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (n_done == 0 && t < 5000) begin
            @(negedge clk);
            t++;
            if (poke && t == 2) begin
                start = 1'b1; mode = 2'd0; addr = 19'h55555;
            end
            if (poke && t == 3) start = 1'b0;
        end
        repeat (4) @(negedge clk);
        check(n_done == 1, {tag, " R9 done count"}, n_done, 1);
        check(e_done == 0, {tag, " R9 done with mreq high"}, e_done, 0);
        check(n_wr == exp_wr, {tag, " R7 write pulses"}, n_wr, exp_wr);
        check(mem.num() == exp_wr, {tag, " R2 written locations"}, mem.num(), exp_wr);
        check(n_rd == exp_rd, {tag, " R4 read pulses"}, n_rd, exp_rd);
        check(n_mfall == ((exp_wr + exp_rd) > 0 ? 1 : 0), {tag, " R7/R8 mreq falls"},
              n_mfall, (exp_wr + exp_rd) > 0 ? 1 : 0);
        check(e_wwidth == 0 && e_setup == 0 && e_hold == 0, {tag, " R3 write timing"},
              e_wwidth + e_setup + e_hold, 0);
        check(e_rwidth == 0 && e_cont == 0, {tag, " R4 read timing"}, e_rwidth + e_cont, 0);
        for (int k = 0; k < exp_wr; k++) begin
            ea = a + 19'(k);
            eb = (m == 2'd3) ? 8'(8'h30 + k) : d;
            if (mem.exists(int'(ea)))
                check(mem[int'(ea)] == eb, {tag, " R2/R5/R6 byte"}, mem[int'(ea)], eb);
            else
                check(1'b0, {tag, " R2 address missing"}, 0, ea);
        end
        if (exp_rd > 0)
            check(rdata == rd_pat(a), {tag, " R4 captured byte"}, rdata, rd_pat(a));
        check_idle({tag, " R1 idle after"});
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_stats();
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset release");

        for (int i = 0; i < NV; i++)
            run_op(V_MODE[i], V_ADDR[i], V_DATA[i], V_LEN[i], V_GAP[i], V_NWR[i], V_NRD[i], 1'b0);

        // R10: a read start in the middle of a fill is ignored
        run_op(2'd2, 19'h01000, 8'h5C, 3, 1'b0, 3, 0, 1'b1);
        check(n_rd == 0, "R10 no read from ignored start", n_rd, 0);

        // R11: single write with a large length still writes one byte
        run_op(2'd1, 19'h00FFF, 8'hE1, 1000, 1'b0, 1, 0, 1'b0);

        // R1: reset in the middle of a copy burst returns the bus to idle
        clear_stats();
        gap_en = 1'b0;
        @(negedge clk);
        start = 1'b1; mode = 2'd3; addr = 19'h00400; len = 32'd8;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check(!mreq_n, "R7 mreq low mid burst", mreq_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after mid-burst reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 stays idle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule